// File: doc/BRIEF.md
# Half-Width Flit Sharing Input Datapath

This block is the receive and injection side of one router port whose channel, W bits wide, moves either one full flit or up to two independent short flits per cycle. The channel is viewed as two half-width lanes: the upper lane and the lower lane. At injection, a detector classifies a W-bit flit as short when it can be carried in one lane. It then produces the half-width code word for that flit. At ejection, a matching expander rebuilds the full flit from a code word.

On reception, a link word is steered into per-virtual-channel FIFOs. A full flit goes to the one virtual channel named in the upper VC field. A shared word carries one VC identifier per lane, so its two halves are written into two different FIFOs in the same cycle. On the switch side, the allocator names a VC for each lane. A second layer of per-lane muxes then places each selected short flit in the upper or the lower half of the crossbar input word. A full flit from one VC can instead fill both halves. The FIFOs themselves are plain and full-width. Only the steering logic around them splits the word into halves.

Top module: `hfs_share_in`

## Requirements
- R1: A flit that is all zeros or all ones is short. Its code word has bit H-1 set to 1, bit 0 equal to the pattern (0 for zeros, 1 for ones), and all other bits 0, where H = W/2. This pattern case takes priority over R2.
- R2: Any other flit whose bits W-1 down to H-1 are all zero is short, with code word {1'b0, flit[H-2:0]}. A flit that is neither R1 nor R2 is not short, and its code word output is 0.
- R3: The expander turns a code word with bit H-1 = 1 into W copies of bit 0. It turns a code word with bit H-1 = 0 into its low H-1 bits, zero-extended to W bits.
- R4: With lnk_full_i = 1, the whole W-bit word is written as one full flit into the VC given by lnk_vc_hi_i. In that cycle the lane valids and lnk_vc_lo_i have no effect, and no other VC receives an entry.
- R5: With lnk_full_i = 0 and both lane valids set, the upper half (bits W-1..H) is written into VC lnk_vc_hi_i and the lower half (bits H-1..0) into VC lnk_vc_lo_i, in the same cycle.
- R6: With lnk_full_i = 0, a lane whose valid is 0 writes nothing, even though its VC field names some VC. A lone short flit may travel in either lane.
- R7: Each VC is first-in first-out. vc_empty_o[v] is 1 exactly when VC v holds no entry. vc_short_o[v] is 1 when VC v is non-empty and its head entry is a short flit.
- R8: With xb_full_i = 1, xb_data_o equals the head full flit of VC xb_vc_hi_i, and xb_full_o, xb_vld_hi_o and xb_vld_lo_o are all 1. That entry is removed at the next clock edge.
- R9: With xb_full_i = 0, the upper half of xb_data_o carries the head short flit of VC xb_vc_hi_i when xb_vld_hi_i = 1, and the lower half carries that of VC xb_vc_lo_i when xb_vld_lo_i = 1. Any VC may feed either half. An unused half is zero and has its valid output low. Each entry that is used is removed at the next edge.
- R10: After reset every VC is empty, and with no select asserted the crossbar valid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inj_flit_i | input | W | Flit offered at injection |
| inj_short_o | output | 1 | Flit fits in one lane |
| inj_half_o | output | W/2 | Half-width code word of the flit |
| lnk_full_i | input | 1 | Link word is one full flit |
| lnk_vld_hi_i | input | 1 | Upper lane holds a short flit |
| lnk_vld_lo_i | input | 1 | Lower lane holds a short flit |
| lnk_vc_hi_i | input | log2(NV) | VC of upper lane or of a full flit |
| lnk_vc_lo_i | input | log2(NV) | VC of lower lane |
| lnk_data_i | input | W | Link word |
| vc_empty_o | output | NV | Per-VC empty flag |
| vc_short_o | output | NV | Per-VC head-is-short flag |
| xb_full_i | input | 1 | Send a full flit from xb_vc_hi_i |
| xb_vld_hi_i | input | 1 | Fill the upper crossbar half |
| xb_vld_lo_i | input | 1 | Fill the lower crossbar half |
| xb_vc_hi_i | input | log2(NV) | VC feeding the upper half or full flit |
| xb_vc_lo_i | input | log2(NV) | VC feeding the lower half |
| xb_data_o | output | W | Crossbar input word |
| xb_full_o | output | 1 | Word is a full flit |
| xb_vld_hi_o | output | 1 | Upper half in use |
| xb_vld_lo_o | output | 1 | Lower half in use |
| ej_half_i | input | W/2 | Code word at ejection |
| ej_flit_o | output | W | Expanded flit |

## Verification
The checker relies on correct upstream credit flow control: no VC is written while it is full, and a shared link word never names the same VC for both lanes. It also assumes the allocator obeys three rules. It picks only non-empty VCs. It never names one VC for both lanes in one cycle. It asks for a full read only when the head of that VC is full. The bench stays within these rules by using distinct VCs in every shared word and by never holding more than three entries in a VC. It issues reads only for VCs it has just filled, with the kind it wrote.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  typedef enum logic {
    KIND_FULL  = 1'b0,
    KIND_SHORT = 1'b1
  } kind_e;
endpackage

// File: rtl/hfs_short_enc.sv
module hfs_short_enc #(
  parameter int W = 64,
  localparam int H = W / 2
) (
  input  logic [W-1:0] flit_i,
  output logic         short_o,
  output logic [H-1:0] half_o
);
  logic all0, all1, narrow;

  assign all0   = ~|flit_i;
  assign all1   = &flit_i;
  assign narrow = ~|flit_i[W-1:H-1];

  always_comb begin
    short_o = 1'b0;
    half_o  = '0;
    if (all0 || all1) begin
      short_o     = 1'b1;
      half_o[H-1] = 1'b1;
      half_o[0]   = all1;
    end else if (narrow) begin
      short_o = 1'b1;
      half_o  = {1'b0, flit_i[H-2:0]};
    end
  end
endmodule

// File: rtl/hfs_short_dec.sv
module hfs_short_dec #(
  parameter int W = 64,
  localparam int H = W / 2
) (
  input  logic [H-1:0] half_i,
  output logic [W-1:0] flit_o
);
  always_comb begin
    if (half_i[H-1]) flit_o = {W{half_i[0]}};
    else             flit_o = {{(H+1){1'b0}}, half_i[H-2:0]};
  end
endmodule

// File: rtl/hfs_vc_fifo.sv
module hfs_vc_fifo #(
  parameter int DW    = 65,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_i) wp <= wp + 1'b1;
      if (rd_i) rp <= rp + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, wr_i} - {{AW{1'b0}}, rd_i};
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wp] <= wdata_i;
  end

  assign rdata_o = mem[rp];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == (AW+1)'(DEPTH));
endmodule

// File: rtl/hfs_lane_demux.sv
module hfs_lane_demux
  import hfs_pkg::*;
#(
  parameter int W   = 64,
  parameter int NV  = 4,
  localparam int H  = W / 2,
  localparam int VCW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic                full_i,
  input  logic                vld_hi_i,
  input  logic                vld_lo_i,
  input  logic [VCW-1:0]      vc_hi_i,
  input  logic [VCW-1:0]      vc_lo_i,
  input  logic [W-1:0]        data_i,
  output logic [NV-1:0]       wr_o,
  output logic [NV-1:0][W:0]  wdata_o
);
  for (genvar v = 0; v < NV; v++) begin : g_vc
    logic hit_hi, hit_lo;
    assign hit_hi = (vc_hi_i == VCW'(v));
    assign hit_lo = (vc_lo_i == VCW'(v));

    always_comb begin
      if (full_i) begin
        wr_o[v]    = hit_hi;
        wdata_o[v] = {KIND_FULL, data_i};
      end else begin
        wr_o[v] = (vld_hi_i && hit_hi) || (vld_lo_i && hit_lo);
        if (vld_hi_i && hit_hi) wdata_o[v] = {KIND_SHORT, {H{1'b0}}, data_i[W-1:H]};
        else                    wdata_o[v] = {KIND_SHORT, {H{1'b0}}, data_i[H-1:0]};
      end
    end
  end
endmodule

// File: rtl/hfs_half_mux.sv
module hfs_half_mux #(
  parameter int W   = 64,
  parameter int NV  = 4,
  localparam int H  = W / 2,
  localparam int VCW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic [NV-1:0][W:0] head_i,
  input  logic               full_i,
  input  logic               vld_hi_i,
  input  logic               vld_lo_i,
  input  logic [VCW-1:0]     vc_hi_i,
  input  logic [VCW-1:0]     vc_lo_i,
  output logic [NV-1:0]      rd_o,
  output logic [W-1:0]       data_o,
  output logic               full_o,
  output logic               vld_hi_o,
  output logic               vld_lo_o
);
  logic [W:0]   word_hi, word_lo;
  logic [H-1:0] lane_hi, lane_lo;

  assign word_hi = head_i[vc_hi_i];
  assign word_lo = head_i[vc_lo_i];

  // second mux layer: each half picks its own VC or stays idle
  assign lane_hi = vld_hi_i ? word_hi[H-1:0] : '0;
  assign lane_lo = vld_lo_i ? word_lo[H-1:0] : '0;

  always_comb begin
    if (full_i) data_o = word_hi[W-1:0];
    else        data_o = {lane_hi, lane_lo};
  end

  for (genvar v = 0; v < NV; v++) begin : g_rd
    assign rd_o[v] = full_i ? (vc_hi_i == VCW'(v))
                   : ((vld_hi_i && vc_hi_i == VCW'(v)) || (vld_lo_i && vc_lo_i == VCW'(v)));
  end

  assign full_o   = full_i;
  assign vld_hi_o = full_i | vld_hi_i;
  assign vld_lo_o = full_i | vld_lo_i;
endmodule

// File: rtl/hfs_share_in.sv
module hfs_share_in #(
  parameter int W     = 64,
  parameter int NV    = 4,
  parameter int DEPTH = 4,
  localparam int H    = W / 2,
  localparam int VCW  = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   inj_flit_i,
  output logic           inj_short_o,
  output logic [H-1:0]   inj_half_o,
  input  logic           lnk_full_i,
  input  logic           lnk_vld_hi_i,
  input  logic           lnk_vld_lo_i,
  input  logic [VCW-1:0] lnk_vc_hi_i,
  input  logic [VCW-1:0] lnk_vc_lo_i,
  input  logic [W-1:0]   lnk_data_i,
  output logic [NV-1:0]  vc_empty_o,
  output logic [NV-1:0]  vc_short_o,
  input  logic           xb_full_i,
  input  logic           xb_vld_hi_i,
  input  logic           xb_vld_lo_i,
  input  logic [VCW-1:0] xb_vc_hi_i,
  input  logic [VCW-1:0] xb_vc_lo_i,
  output logic [W-1:0]   xb_data_o,
  output logic           xb_full_o,
  output logic           xb_vld_hi_o,
  output logic           xb_vld_lo_o,
  input  logic [H-1:0]   ej_half_i,
  output logic [W-1:0]   ej_flit_o
);
  logic [NV-1:0]      wr_en, rd_en, fifo_full;
  logic [NV-1:0][W:0] wr_data, head;

  hfs_short_enc #(.W(W)) u_enc (
    .flit_i (inj_flit_i),
    .short_o(inj_short_o),
    .half_o (inj_half_o)
  );

  hfs_short_dec #(.W(W)) u_dec (
    .half_i(ej_half_i),
    .flit_o(ej_flit_o)
  );

  hfs_lane_demux #(.W(W), .NV(NV)) u_demux (
    .full_i  (lnk_full_i),
    .vld_hi_i(lnk_vld_hi_i),
    .vld_lo_i(lnk_vld_lo_i),
    .vc_hi_i (lnk_vc_hi_i),
    .vc_lo_i (lnk_vc_lo_i),
    .data_i  (lnk_data_i),
    .wr_o    (wr_en),
    .wdata_o (wr_data)
  );

  for (genvar v = 0; v < NV; v++) begin : g_fifo
    hfs_vc_fifo #(.DW(W+1), .DEPTH(DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en[v]),
      .wdata_i(wr_data[v]),
      .rd_i   (rd_en[v]),
      .rdata_o(head[v]),
      .empty_o(vc_empty_o[v]),
      .full_o (fifo_full[v])
    );
    assign vc_short_o[v] = ~vc_empty_o[v] & head[v][W];
  end

  hfs_half_mux #(.W(W), .NV(NV)) u_mux (
    .head_i  (head),
    .full_i  (xb_full_i),
    .vld_hi_i(xb_vld_hi_i),
    .vld_lo_i(xb_vld_lo_i),
    .vc_hi_i (xb_vc_hi_i),
    .vc_lo_i (xb_vc_lo_i),
    .rd_o    (rd_en),
    .data_o  (xb_data_o),
    .full_o  (xb_full_o),
    .vld_hi_o(xb_vld_hi_o),
    .vld_lo_o(xb_vld_lo_o)
  );
endmodule

// File: rtl/hfs_share_in_chk.sv
module hfs_share_in_chk #(
  parameter int W  = 64,
  parameter int NV = 4,
  localparam int H = W / 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  inj_flit_i,
  input logic          inj_short_o,
  input logic [H-1:0]  inj_half_o,
  input logic          lnk_full_i,
  input logic          lnk_vld_hi_i,
  input logic          lnk_vld_lo_i,
  input logic [NV-1:0] wr_en,
  input logic [NV-1:0] fifo_full,
  input logic [NV-1:0] vc_empty_o,
  input logic [W-1:0]  xb_data_o,
  input logic          xb_full_o,
  input logic          xb_vld_hi_o,
  input logic          xb_vld_lo_o
);
  AST_PATTERN_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_short_o && inj_half_o[H-1]) |-> ((inj_flit_i == '0) || (&inj_flit_i))); // R1
  AST_FULL_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_full_i |-> ($countones(wr_en) == 1)); // R4
  AST_SPLIT_TWO_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lnk_full_i && lnk_vld_hi_i && lnk_vld_lo_i) |-> ($countones(wr_en) == 2)); // R5
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lnk_full_i && !lnk_vld_hi_i && !lnk_vld_lo_i) |-> (wr_en == '0)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en & fifo_full) == '0)); // R7
  AST_EMPTY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vc_empty_o & ~wr_en) != '0) |=> (($past(vc_empty_o & ~wr_en) & ~vc_empty_o) == '0)); // R7
  AST_FULL_BOTH_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xb_full_o |-> (xb_vld_hi_o && xb_vld_lo_o)); // R8
  AST_IDLE_HALF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xb_full_o && !xb_vld_hi_o) |-> (xb_data_o[W-1:H] == '0)); // R9
endmodule

bind hfs_share_in hfs_share_in_chk #(.W(W), .NV(NV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .inj_flit_i  (inj_flit_i),
  .inj_short_o (inj_short_o),
  .inj_half_o  (inj_half_o),
  .lnk_full_i  (lnk_full_i),
  .lnk_vld_hi_i(lnk_vld_hi_i),
  .lnk_vld_lo_i(lnk_vld_lo_i),
  .wr_en       (wr_en),
  .fifo_full   (fifo_full),
  .vc_empty_o  (vc_empty_o),
  .xb_data_o   (xb_data_o),
  .xb_full_o   (xb_full_o),
  .xb_vld_hi_o (xb_vld_hi_o),
  .xb_vld_lo_o (xb_vld_lo_o)
);

// File: tb/hfs_share_in_tb_top.sv
module hfs_share_in_tb_top;
  localparam int W = 64, NV = 4, H = 32, VCW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] inj_flit = '0, lnk_data = '0;
  logic inj_short;
  logic [H-1:0] inj_half, ej_half = '0;
  logic lnk_full = 0, lnk_vh = 0, lnk_vl = 0;
  logic [VCW-1:0] lnk_vch = '0, lnk_vcl = '0, xb_vch = '0, xb_vcl = '0;
  logic [NV-1:0] vc_empty, vc_short;
  logic xb_full = 0, xb_vh = 0, xb_vl = 0;
  logic [W-1:0] xb_data, ej_flit;
  logic xb_full_o, xb_vh_o, xb_vl_o;

  int checks = 0, errors = 0;
  bit done = 0;

  hfs_share_in #(.W(W), .NV(NV), .DEPTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .inj_flit_i(inj_flit), .inj_short_o(inj_short), .inj_half_o(inj_half),
    .lnk_full_i(lnk_full), .lnk_vld_hi_i(lnk_vh), .lnk_vld_lo_i(lnk_vl),
    .lnk_vc_hi_i(lnk_vch), .lnk_vc_lo_i(lnk_vcl), .lnk_data_i(lnk_data),
    .vc_empty_o(vc_empty), .vc_short_o(vc_short),
    .xb_full_i(xb_full), .xb_vld_hi_i(xb_vh), .xb_vld_lo_i(xb_vl),
    .xb_vc_hi_i(xb_vch), .xb_vc_lo_i(xb_vcl),
    .xb_data_o(xb_data), .xb_full_o(xb_full_o), .xb_vld_hi_o(xb_vh_o), .xb_vld_lo_o(xb_vl_o),
    .ej_half_i(ej_half), .ej_flit_o(ej_flit)
  );

  // {flit, short, code word}
  localparam logic [96:0] VEC [7] = '{
    {64'h0000_0000_0000_0000, 1'b1, 32'h8000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 32'h8000_0001},
    {64'h0000_0000_1234_5678, 1'b1, 32'h1234_5678},
    {64'h0000_0000_0000_0001, 1'b1, 32'h0000_0001},
    {64'h0000_0000_8000_0000, 1'b0, 32'h0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 32'h0000_0000},
    {64'h0000_0001_0000_0000, 1'b0, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lnk_put(input logic f, input logic vh, input logic vl,
                         input logic [VCW-1:0] ch, input logic [VCW-1:0] cl,
                         input logic [W-1:0] d);
    @(negedge clk);
    lnk_full = f; lnk_vh = vh; lnk_vl = vl; lnk_vch = ch; lnk_vcl = cl; lnk_data = d;
    @(negedge clk);
    lnk_full = 0; lnk_vh = 0; lnk_vl = 0; lnk_data = '0;
    #1;
  endtask

  task automatic xb_sel(input logic f, input logic vh, input logic vl,
                        input logic [VCW-1:0] ch, input logic [VCW-1:0] cl);
    @(negedge clk);
    xb_full = f; xb_vh = vh; xb_vl = vl; xb_vch = ch; xb_vcl = cl;
    #1;
  endtask

  task automatic xb_idle();
    @(negedge clk);
    xb_full = 0; xb_vh = 0; xb_vl = 0;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 empty after reset", W'(vc_empty), W'(4'hF));
    check("R10 valids after reset", W'({xb_full_o, xb_vh_o, xb_vl_o}), '0);
    rst_n = 1'b1;

    // encoder table, round trip through expander
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      inj_flit = VEC[i][96:33];
      ej_half  = VEC[i][31:0];
      #1;
      check(VEC[i][31] ? "R1 short flag" : "R2 short flag", W'(inj_short), W'(VEC[i][32]));
      check(VEC[i][31] ? "R1 code word" : "R2 code word", W'(inj_half), W'(VEC[i][31:0]));
      if (VEC[i][32]) check("R3 expand", ej_flit, VEC[i][96:33]);
    end
    @(negedge clk);
    ej_half = 32'h0000_00A5; #1;
    check("R3 narrow expand", ej_flit, 64'h0000_0000_0000_00A5);
    ej_half = 32'hC000_0000; #1;
    check("R3 zeros expand", ej_flit, '0);

    // R4 full flit, lane fields ignored
    lnk_put(1, 1, 1, 2'd2, 2'd3, 64'hDEAD_BEEF_0123_4567);
    check("R4 only VC2 written", W'(vc_empty), W'(4'b1011));
    check("R7 head kind full", W'(vc_short), '0);
    xb_sel(1, 0, 0, 2'd2, 2'd0);
    check("R8 full data", xb_data, 64'hDEAD_BEEF_0123_4567);
    check("R8 flags", W'({xb_full_o, xb_vh_o, xb_vl_o}), W'(3'b111));
    xb_idle();
    check("R8 popped", W'(vc_empty), W'(4'hF));

    // R5 shared word into VC1 (upper) and VC3 (lower), read with lanes swapped
    lnk_put(0, 1, 1, 2'd1, 2'd3, {32'hAAAA_0001, 32'h0000_BBBB});
    check("R5 two VCs written", W'(vc_empty), W'(4'b0101));
    check("R7 heads short", W'(vc_short), W'(4'b1010));
    xb_sel(0, 1, 1, 2'd3, 2'd1);
    check("R9 swapped halves", xb_data, {32'h0000_BBBB, 32'hAAAA_0001});
    check("R9 flags", W'({xb_full_o, xb_vh_o, xb_vl_o}), W'(3'b011));
    xb_idle();
    check("R9 both popped", W'(vc_empty), W'(4'hF));

    // R6 lone lower-lane flit; upper VC field names VC1 but is invalid
    lnk_put(0, 0, 1, 2'd1, 2'd0, {32'hFFFF_FFFF, 32'h0000_0C0C});
    check("R6 only VC0 written", W'(vc_empty), W'(4'b1110));
    xb_sel(0, 1, 0, 2'd0, 2'd2);
    check("R9 lone flit in upper half", xb_data, {32'h0000_0C0C, 32'h0});
    check("R9 lone flags", W'({xb_full_o, xb_vh_o, xb_vl_o}), W'(3'b010));
    xb_idle();

    // R7 ordering within one VC
    lnk_put(0, 0, 1, 2'd0, 2'd2, 64'h1);
    lnk_put(0, 0, 1, 2'd0, 2'd2, 64'h2);
    lnk_put(0, 0, 1, 2'd0, 2'd2, 64'h3);
    check("R7 VC2 holds entries", W'(vc_empty), W'(4'b1011));
    xb_sel(0, 0, 1, 2'd0, 2'd2);
    check("R7 first", xb_data, 64'h1);
    @(negedge clk); #1;
    check("R7 second", xb_data, 64'h2);
    @(negedge clk); #1;
    check("R7 third", xb_data, 64'h3);
    xb_idle();
    check("R7 drained", W'(vc_empty), W'(4'hF));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule